// File: doc/BRIEF.md
# Stochastic Piecewise-Linear Activation Unit

This block evaluates a tanh or sigmoid activation over an input in the range (-1, 1) using an 8-segment piecewise-linear fit, f(x) = a·x + b. The input arrives as a sign bit and an 8-bit magnitude scaled by 2^-8. The top three bits of the magnitude choose a segment, and two small constant tables supply that segment's slope and offset. Each coefficient is an 8-bit value scaled by 2^-8.

The slope-times-input product is formed in the unipolar stochastic domain. Two stream generators share one window index and emit one bit each per cycle. The bits are ANDed, and a ones counter turns the product stream back into binary over a 256-cycle window. The segment offset is then added in plain binary, where the table values can absorb the stream error, and the sum is clamped to the 8-bit range.

Negative inputs are folded. tanh is treated as odd, so it gives the same magnitude with the sign flag raised. sigmoid is complemented around one and gives 256 − f(|x|). A user pulses `start` with the operand applied and receives one `done` pulse carrying the result. The result stays on the outputs until the next `done`.

Top module: `sc_pwl_act`

## Requirements
- R1: After reset, `done`, `y_mag` and `y_neg` are all 0.
- R2: With `fn_sel`=1 (tanh), the segment is `x_mag[7:5]`. The slopes for segments 0 to 7 are 255, 247, 232, 213, 189, 165, 141, 117. The offsets are 0, 2, 5, 12, 24, 39, 57, 78.
- R3: With `fn_sel`=0 (sigmoid), the segment is `x_mag[7:5]`. The offsets for segments 0 to 7 are 128, 128, 128, 128, 131, 131, 135, 137. The slopes are 64, 64, 63, 63, 57, 57, 52, 50.
- R4: Over window cycles t = 0..255, the slope stream is 1 when t < a, and the input stream is 1 when the bit-reversed 8-bit t is below `x_mag`. The unsigned result f is the number of cycles in which both streams are 1, plus b, clamped to 255.
- R5: For non-negative inputs, f lies within 5 LSB of floor(a·x_mag/256) + b.
- R6: `done` is high for exactly one cycle. It rises on the 256th rising edge after the edge that accepts `start`.
- R7: A `start` that arrives while a window is running is ignored. A `start` in the `done` cycle or later begins a new window.
- R8: tanh with `x_neg`=1 gives `y_mag` = f. `y_neg` is 1 whenever f is non-zero.
- R9: sigmoid with `x_neg`=1 gives `y_mag` = 256 − f. `y_neg` is 0 for every sigmoid result.
- R10: `fn_sel`, `x_neg` and `x_mag` are captured when `start` is accepted, so later changes have no effect. `y_mag` and `y_neg` change only when `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion when idle |
| fn_sel | input | 1 | 1 selects tanh, 0 selects sigmoid |
| x_neg | input | 1 | Sign of the input, 1 for negative |
| x_mag | input | 8 | Input magnitude, scaled by 2^-8 |
| done | output | 1 | One-cycle pulse when a result is ready |
| y_mag | output | 8 | Result magnitude, scaled by 2^-8 |
| y_neg | output | 1 | Result sign (tanh only) |

## Verification
Every result is due on the 256th rising edge after the accepting edge. It becomes visible in the following low phase of the clock, together with a one-cycle `done`. The bench keeps a behavioural model that steps once per rising edge and predicts `done`, `y_mag` and `y_neg` for every cycle. Each low phase compares all three outputs with the model, so a pulse that arrives early or late, or an output that drifts between pulses, is caught in the cycle where it happens. Starts issued mid-window and held across the `done` cycle exercise the accept rule at both of its edges.

// File: rtl/sc_pwl_pkg.sv
package sc_pwl_pkg;

  typedef enum logic {
    ACT_SIGMOID = 1'b0,
    ACT_TANH    = 1'b1
  } act_sel_e;

  // Per-segment slope, in units of 2^-8
  function automatic int seg_slope(act_sel_e fn, int seg);
    int v;
    if (fn == ACT_TANH) begin
      case (seg)
        0: v = 255;  1: v = 247;  2: v = 232;  3: v = 213;
        4: v = 189;  5: v = 165;  6: v = 141;  7: v = 117;
        default: v = 0;
      endcase
    end else begin
      case (seg)
        0: v = 64;   1: v = 64;   2: v = 63;   3: v = 63;
        4: v = 57;   5: v = 57;   6: v = 52;   7: v = 50;
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  // Per-segment offset, in units of 2^-8
  function automatic int seg_offset(act_sel_e fn, int seg);
    int v;
    if (fn == ACT_TANH) begin
      case (seg)
        0: v = 0;    1: v = 2;    2: v = 5;    3: v = 12;
        4: v = 24;   5: v = 39;   6: v = 57;   7: v = 78;
        default: v = 0;
      endcase
    end else begin
      case (seg)
        0: v = 128;  1: v = 128;  2: v = 128;  3: v = 128;
        4: v = 131;  5: v = 131;  6: v = 135;  7: v = 137;
        default: v = 0;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/sc_coef_rom.sv
module sc_coef_rom #(
  parameter int SEG_BITS = 3,
  parameter int COEF_W   = 8
) (
  input  logic                fn_tanh,
  input  logic [SEG_BITS-1:0] seg,
  output logic [COEF_W-1:0]   slope,
  output logic [COEF_W-1:0]   offset
);
  localparam int SEGS = 1 << SEG_BITS;

  logic [COEF_W-1:0] th_a [SEGS];
  logic [COEF_W-1:0] th_b [SEGS];
  logic [COEF_W-1:0] sg_a [SEGS];
  logic [COEF_W-1:0] sg_b [SEGS];

  for (genvar s = 0; s < SEGS; s++) begin : g_tab
    assign th_a[s] = COEF_W'(sc_pwl_pkg::seg_slope (sc_pwl_pkg::ACT_TANH,    s));
    assign th_b[s] = COEF_W'(sc_pwl_pkg::seg_offset(sc_pwl_pkg::ACT_TANH,    s));
    assign sg_a[s] = COEF_W'(sc_pwl_pkg::seg_slope (sc_pwl_pkg::ACT_SIGMOID, s));
    assign sg_b[s] = COEF_W'(sc_pwl_pkg::seg_offset(sc_pwl_pkg::ACT_SIGMOID, s));
  end

  assign slope  = fn_tanh ? th_a[seg] : sg_a[seg];
  assign offset = fn_tanh ? th_b[seg] : sg_b[seg];
endmodule

// File: rtl/sc_stream_gen.sv
module sc_stream_gen #(
  parameter int W       = 8,
  parameter bit REVERSE = 1'b0
) (
  input  logic [W-1:0] idx,
  input  logic [W-1:0] level,
  output logic         bit_o
);
  if (REVERSE) begin : g_rev
    logic [W-1:0] ridx;
    for (genvar k = 0; k < W; k++) begin : g_bit
      assign ridx[k] = idx[W-1-k];
    end
    assign bit_o = (ridx < level);
  end else begin : g_fwd
    assign bit_o = (idx < level);
  end
endmodule

// File: rtl/sc_ones_counter.sv
module sc_ones_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             bit_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next
);
  logic [CNT_W-1:0] cnt_q;

  assign count_next = cnt_q + CNT_W'(bit_in);
  assign count      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (en)    cnt_q <= count_next;
  end
endmodule

// File: rtl/sc_pwl_act.sv
module sc_pwl_act #(
  parameter int DATA_W   = 8,
  parameter int SEG_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fn_sel,
  input  logic              x_neg,
  input  logic [DATA_W-1:0] x_mag,
  output logic              done,
  output logic [DATA_W-1:0] y_mag,
  output logic              y_neg
);
  localparam int WIN_LEN = 1 << DATA_W;
  localparam int ACC_W   = DATA_W + 1;
  localparam logic [ACC_W:0] SUM_MAX = (ACC_W+1)'(WIN_LEN - 1);

  // Offset add in binary, clamped to the output range
  function automatic logic [DATA_W-1:0] sat_sum(logic [ACC_W-1:0] cnt,
                                                logic [DATA_W-1:0] off);
    logic [ACC_W:0] s;
    s = {1'b0, cnt} + (ACC_W+1)'(off);
    if (s > SUM_MAX) return '1;
    return s[DATA_W-1:0];
  endfunction

  // Negative-input folding: odd for tanh, complement for sigmoid
  function automatic logic [DATA_W:0] fold_sign(logic [DATA_W-1:0] f,
                                                logic tanh_fn, logic neg);
    logic [DATA_W-1:0] m;
    logic              s;
    if (tanh_fn) begin
      m = f;
      s = neg && (f != '0);
    end else begin
      s = 1'b0;
      if (!neg)         m = f;
      else if (f == '0) m = '1;
      else              m = (~f) + 1'b1;
    end
    return {s, m};
  endfunction

  // Captured operand and window state
  logic              busy_q;
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] a_q, b_q, m_q;
  logic              neg_q, tanh_q;
  logic              done_q, yneg_q;
  logic [DATA_W-1:0] ymag_q;

  // Named internal events
  logic              start_acc;
  logic              win_last;
  logic              a_bit, x_bit, prod_bit;
  logic [SEG_BITS-1:0] seg_sel;
  logic [DATA_W-1:0] rom_slope, rom_offset;
  logic [ACC_W-1:0]  acc_q, acc_next;
  logic [DATA_W:0]   folded;

  assign start_acc = start && !busy_q;
  assign win_last  = busy_q && (idx_q == '1);
  assign seg_sel   = x_mag[DATA_W-1 -: SEG_BITS];

  sc_coef_rom #(.SEG_BITS(SEG_BITS), .COEF_W(DATA_W)) u_rom (
    .fn_tanh (fn_sel),
    .seg     (seg_sel),
    .slope   (rom_slope),
    .offset  (rom_offset)
  );

  sc_stream_gen #(.W(DATA_W), .REVERSE(1'b0)) u_sng_slope (
    .idx   (idx_q),
    .level (a_q),
    .bit_o (a_bit)
  );

  sc_stream_gen #(.W(DATA_W), .REVERSE(1'b1)) u_sng_input (
    .idx   (idx_q),
    .level (m_q),
    .bit_o (x_bit)
  );

  assign prod_bit = a_bit & x_bit;

  sc_ones_counter #(.CNT_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .en         (busy_q),
    .bit_in     (prod_bit),
    .count      (acc_q),
    .count_next (acc_next)
  );

  assign folded = fold_sign(sat_sum(acc_next, b_q), tanh_q, neg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      neg_q  <= 1'b0;
      tanh_q <= 1'b0;
      done_q <= 1'b0;
      ymag_q <= '0;
      yneg_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_acc) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        a_q    <= rom_slope;
        b_q    <= rom_offset;
        m_q    <= x_mag;
        neg_q  <= x_neg;
        tanh_q <= fn_sel;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (win_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          yneg_q <= folded[DATA_W];
          ymag_q <= folded[DATA_W-1:0];
        end
      end
    end
  end

  assign done  = done_q;
  assign y_mag = ymag_q;
  assign y_neg = yneg_q;
endmodule

// File: rtl/sc_pwl_act_chk.sv
module sc_pwl_act_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              win_last,
  input logic              done,
  input logic              tanh_fn,
  input logic [DATA_W-1:0] idx,
  input logic [DATA_W:0]   acc,
  input logic [DATA_W-1:0] y_mag,
  input logic              y_neg
);
  localparam int SPAN_W = DATA_W + 2;
  localparam logic [SPAN_W-1:0] WIN = SPAN_W'(1 << DATA_W);

  logic [SPAN_W-1:0] span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               span <= '0;
    else if (start && !busy)  span <= '0;
    else if (busy)            span <= span + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (span == WIN)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> ($stable(y_mag) && $stable(y_neg))); // R10
  AST_SIGMOID_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tanh_fn) |-> !y_neg); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, idx} >= acc)); // R4
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R7
endmodule

bind sc_pwl_act sc_pwl_act_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy_q),
  .win_last (win_last),
  .done     (done),
  .tanh_fn  (tanh_q),
  .idx      (idx_q),
  .acc      (acc_q),
  .y_mag    (y_mag),
  .y_neg    (y_neg)
);

// File: tb/tb_sc_pwl_act.sv
module tb_sc_pwl_act;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       fn_sel = 1'b0;
  logic       x_neg = 1'b0;
  logic [7:0] x_mag = 8'd0;
  logic       done;
  logic [7:0] y_mag;
  logic       y_neg;

  sc_pwl_act dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fn_sel(fn_sel),
    .x_neg(x_neg), .x_mag(x_mag), .done(done), .y_mag(y_mag), .y_neg(y_neg)
  );

  always #5 clk = ~clk;

  // R2 tanh coefficients, R3 sigmoid coefficients
  int th_a [8] = '{255, 247, 232, 213, 189, 165, 141, 117};
  int th_b [8] = '{0, 2, 5, 12, 24, 39, 57, 78};
  int sg_a [8] = '{64, 64, 63, 63, 57, 57, 52, 50};
  int sg_b [8] = '{128, 128, 128, 128, 131, 131, 135, 137};

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  function automatic int rev8(int v);
    int r = 0;
    for (int k = 0; k < 8; k++) if (v[k]) r = r | (1 << (7 - k));
    return r;
  endfunction

  // R4: ones where both streams are high, over the 256-cycle window
  function automatic int both_ones(int a, int m);
    int c = 0;
    for (int t = 0; t < 256; t++) if ((t < a) && (rev8(t) < m)) c++;
    return c;
  endfunction

  // Reference model state
  bit    mbusy = 0, mdone = 0;
  int    mt = 0, mmag = 0, mneg = 0;
  int    p_mag, p_neg, p_ideal;
  bit    p_fn, p_xn;
  string p_tag, mtag;
  int    r_ideal;
  bit    r_fn, r_xn;

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mdone = 0; mt = 0; mmag = 0; mneg = 0;
    end else begin
      mdone = 0;
      if (mbusy) begin
        mt++;
        if (mt == 256) begin
          mbusy = 0; mdone = 1; mmag = p_mag; mneg = p_neg;
          mtag = p_tag; r_ideal = p_ideal; r_fn = p_fn; r_xn = p_xn;
        end
      end else if (start) begin
        int sg, a, b, f;
        mbusy = 1; mt = 0;
        sg = int'(x_mag) >> 5;
        a = fn_sel ? th_a[sg] : sg_a[sg];
        b = fn_sel ? th_b[sg] : sg_b[sg];
        f = both_ones(a, int'(x_mag)) + b;
        if (f > 255) f = 255;
        p_ideal = (a * int'(x_mag)) / 256 + b;
        p_fn = fn_sel; p_xn = x_neg;
        if (fn_sel) begin
          p_mag = f; p_neg = (x_neg && f != 0) ? 1 : 0;
          p_tag = x_neg ? "R8/R4" : "R2/R4";
        end else begin
          p_neg = 0;
          p_mag = x_neg ? ((f == 0) ? 255 : 256 - f) : f;
          p_tag = x_neg ? "R9/R4" : "R3/R4";
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare on every clock, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      if (cyc == 2) begin
        chk(done == 1'b0, "R1", int'(done), 0);
        chk(y_mag == 8'd0, "R1", int'(y_mag), 0);
        chk(y_neg == 1'b0, "R1", int'(y_neg), 0);
      end
    end else begin
      chk(done == mdone, "R6/R7", int'(done), int'(mdone));
      chk(int'(y_mag) == mmag, mdone ? mtag : "R10", int'(y_mag), mmag);
      chk(int'(y_neg) == mneg, mdone ? mtag : "R10", int'(y_neg), mneg);
      if (mdone && !r_xn) begin
        int d = int'(y_mag) - r_ideal;
        chk(d <= 5 && d >= -5, "R5", int'(y_mag), r_ideal);
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // mode 0: plain; 1: start pulse mid-window with changed inputs (R7, R10);
  // 2: start held through the done cycle, so a second window begins (R7)
  task automatic run(bit fn, bit ng, int m, int mode);
    @(negedge clk);
    fn_sel = fn; x_neg = ng; x_mag = 8'(m); start = 1'b1;
    @(negedge clk);
    if (mode != 2) start = 1'b0;
    if (mode == 1) begin
      repeat (100) @(negedge clk);
      start = 1'b1; x_mag = ~x_mag; fn_sel = !fn; x_neg = !ng;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (mode == 2) begin
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
    end
    @(negedge clk);
  endtask

  int mags [10] = '{0, 31, 32, 64, 100, 128, 160, 200, 224, 255};

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int f = 1; f >= 0; f--)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 10; i++)
          run(f[0], s[0], mags[i], 0);
    run(1'b1, 1'b0, 180, 1);
    run(1'b0, 1'b1, 90, 1);
    run(1'b1, 1'b1, 240, 2);
    run(1'b0, 1'b0, 17, 2);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule